// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides its clock by a programmable ratio built from a two-modulus prescaler, a 6-bit swallow count and a 7-bit program count. Each clock edge is one input cycle. A pair-select bit chooses the prescaler modulus P. With that bit at 0 the prescaler divides by 32 or 33, and with it at 1 by 64 or 65. In one division cycle the prescaler first divides by P+1 while the swallow count runs out. It then divides by P until the program count runs out. The total ratio is P·B + A input cycles.

At the end of every division cycle the block emits a single one-cycle pulse. It then reloads its counters and modulus from the most recent legal programming values. Programming values may change at any time, but they only act at a cycle boundary. If a setting is illegal, the block raises an error flag and keeps the last legal setting. A synthesizer loop would compare this pulse against a reference.

Top module: `psdiv_top`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `div_pulse_o` and `cfg_err_o` are 0. After reset the active setting is A=0, B=3, pair-select 0, so the first pulse comes 96 cycles after reset is released.
- R2: Under a legal setting, consecutive pulses are exactly P·B + A clock cycles apart.
- R3: Pair-select 1 gives P = 64 (divide by 64 or 65). Pair-select 0 gives P = 32 (divide by 32 or 33).
- R4: Each pulse on `div_pulse_o` is high for exactly one clock cycle.
- R5: The inputs are sampled on every edge into a held setting. The division cycle in progress finishes with its old ratio. The next cycle uses the held setting that stood before the edge that ended the current cycle.
- R6: A program count below 3 is illegal. `cfg_err_o` is 1 in the cycle after such inputs are sampled.
- R7: A swallow count greater than the program count is illegal and sets `cfg_err_o` in the same way.
- R8: A swallow count greater than P for the selected pair is illegal and sets `cfg_err_o` in the same way. For example, A=40 is illegal with pair 0 and legal with pair 1.
- R9: An illegal setting leaves the held setting unchanged, so the pulse period keeps the last legal ratio.
- R10: `cfg_err_o` returns to 0 one cycle after legal inputs are sampled, and the new legal setting takes effect at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock being divided; one edge is one input cycle |
| rst | input | 1 | Synchronous active-high reset |
| swallow_cnt_i | input | 6 | Swallow count A |
| prog_cnt_i | input | 7 | Program count B |
| pair_sel_i | input | 1 | Prescaler pair select: 0 gives 32/33, 1 gives 64/65 |
| div_pulse_o | output | 1 | One-cycle pulse at the end of each division cycle |
| cfg_err_o | output | 1 | Registered flag: the last sampled setting was illegal |

## Verification
A corrupted swallow or program counter, or a wrong prescaler modulus, shows up as a pulse one or more cycles early or late. It appears at the very next boundary, which is at most 8191 cycles away. A setting loaded at the wrong moment shifts the period of the cycle still running, not of the following one. A wrong legality decision is visible one cycle later on the error flag. It then shows again as a wrong period after the next boundary. Comparing against a cycle-accurate model on every edge catches a slip of a single cycle.

// File: rtl/psdiv_pkg.sv
package psdiv_pkg;
  localparam int SWL_W   = 6;
  localparam int PRG_W   = 7;
  localparam int PRE_LOG = 5;
  localparam int PRG_MIN = 3;

  typedef enum logic {
    PAIR_LO = 1'b0,
    PAIR_HI = 1'b1
  } pair_e;
endpackage

// File: rtl/psdiv_cfg_guard.sv
module psdiv_cfg_guard
  import psdiv_pkg::*;
#(
  parameter int A_W     = SWL_W,
  parameter int B_W     = PRG_W,
  parameter int P_LOG   = PRE_LOG,
  parameter int B_MIN   = PRG_MIN,
  parameter int A_RST   = 0,
  parameter int B_RST   = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  pair_e          pair_in,
  output logic [A_W-1:0] a_held,
  output logic [B_W-1:0] b_held,
  output pair_e          pair_held,
  output logic           err_o
);
  localparam int P_LO = 1 << P_LOG;
  localparam int P_HI = P_LO * 2;

  int   p_sel;
  logic bad;

  always_comb begin
    p_sel = (pair_in == PAIR_HI) ? P_HI : P_LO;
    bad   = (int'(b_in) < B_MIN) || (int'(a_in) > int'(b_in)) || (int'(a_in) > p_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_held    <= A_W'(A_RST);
      b_held    <= B_W'(B_RST);
      pair_held <= PAIR_LO;
      err_o     <= 1'b0;
    end else begin
      err_o <= bad;
      if (!bad) begin
        a_held    <= a_in;
        b_held    <= b_in;
        pair_held <= pair_in;
      end
    end
  end

  p_err_keeps_held_r9: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $stable({a_held, b_held, pair_held}));

  p_held_b_legal_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(b_held) >= B_MIN) && (int'(a_held) <= int'(b_held)));

  p_held_a_vs_p_r8: assert property (@(posedge clk) disable iff (rst)
    int'(a_held) <= ((pair_held == PAIR_HI) ? P_HI : P_LO));
endmodule

// File: rtl/psdiv_prescaler.sv
module psdiv_prescaler #(
  parameter int P_LOG = psdiv_pkg::PRE_LOG
) (
  input  logic clk,
  input  logic rst,
  input  logic pair_hi,
  input  logic extra,
  output logic tick
);
  localparam int CW = P_LOG + 2;
  localparam logic [CW-1:0] LO_M1 = CW'((1 << P_LOG) - 1);
  localparam logic [CW-1:0] HI_M1 = CW'((2 << P_LOG) - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    last = (pair_hi ? HI_M1 : LO_M1) + CW'(extra);
    tick = (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  p_pre_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= HI_M1 + CW'(1));
endmodule

// File: rtl/psdiv_swallow_ctrl.sv
module psdiv_swallow_ctrl
  import psdiv_pkg::*;
#(
  parameter int A_W   = SWL_W,
  parameter int B_W   = PRG_W,
  parameter int A_RST = 0,
  parameter int B_RST = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [A_W-1:0] a_next,
  input  logic [B_W-1:0] b_next,
  input  pair_e          pair_next,
  output logic           extra,
  output pair_e          pair_act,
  output logic           term
);
  logic [A_W-1:0] a_rem;
  logic [B_W-1:0] b_rem;

  always_comb begin
    extra = (a_rem != '0);
    term  = tick && (b_rem == B_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rem    <= A_W'(A_RST);
      b_rem    <= B_W'(B_RST);
      pair_act <= PAIR_LO;
    end else if (term) begin
      a_rem    <= a_next;
      b_rem    <= b_next;
      pair_act <= pair_next;
    end else if (tick) begin
      b_rem <= b_rem - 1'b1;
      if (extra) a_rem <= a_rem - 1'b1;
    end
  end

  p_reload_at_boundary_r5: assert property (@(posedge clk) disable iff (rst)
    !term |=> $stable(pair_act));

  p_counts_ordered_r2: assert property (@(posedge clk) disable iff (rst)
    (b_rem != '0) && (int'(a_rem) <= int'(b_rem)));
endmodule

// File: rtl/psdiv_top.sv
module psdiv_top
  import psdiv_pkg::*;
#(
  parameter int A_W   = SWL_W,
  parameter int B_W   = PRG_W,
  parameter int P_LOG = PRE_LOG,
  parameter int B_MIN = PRG_MIN,
  parameter int A_RST = 0,
  parameter int B_RST = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] swallow_cnt_i,
  input  logic [B_W-1:0] prog_cnt_i,
  input  logic           pair_sel_i,
  output logic           div_pulse_o,
  output logic           cfg_err_o
);
  logic [A_W-1:0] a_held;
  logic [B_W-1:0] b_held;
  pair_e          pair_held;
  pair_e          pair_act;
  logic           extra;
  logic           tick;
  logic           term;

  psdiv_cfg_guard #(
    .A_W(A_W), .B_W(B_W), .P_LOG(P_LOG), .B_MIN(B_MIN), .A_RST(A_RST), .B_RST(B_RST)
  ) guard_i (
    .clk(clk), .rst(rst), .a_in(swallow_cnt_i), .b_in(prog_cnt_i),
    .pair_in(pair_e'(pair_sel_i)), .a_held(a_held), .b_held(b_held),
    .pair_held(pair_held), .err_o(cfg_err_o)
  );

  psdiv_prescaler #(.P_LOG(P_LOG)) pre_i (
    .clk(clk), .rst(rst), .pair_hi(pair_act == PAIR_HI), .extra(extra), .tick(tick)
  );

  psdiv_swallow_ctrl #(
    .A_W(A_W), .B_W(B_W), .A_RST(A_RST), .B_RST(B_RST)
  ) ctrl_i (
    .clk(clk), .rst(rst), .tick(tick), .a_next(a_held), .b_next(b_held),
    .pair_next(pair_held), .extra(extra), .pair_act(pair_act), .term(term)
  );

  always_ff @(posedge clk) begin
    if (rst) div_pulse_o <= 1'b0;
    else     div_pulse_o <= term;
  end

  p_pulse_one_wide_r4: assert property (@(posedge clk) disable iff (rst)
    div_pulse_o |=> !div_pulse_o);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!div_pulse_o && !cfg_err_o));
endmodule

// File: tb/psdiv_top_tb_top.sv
module psdiv_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] swl = 6'd0;
  logic [6:0] prg = 7'd3;
  logic       pair = 1'b0;
  logic       div_pulse;
  logic       cfg_err;

  int    checks = 0;
  int    errors = 0;
  int    pulses = 0;
  bit    started = 1'b0;
  bit    finished = 1'b0;
  string tag = "R1";

  int m_cnt, m_period, m_ha, m_hb, m_hm;
  bit m_pulse, m_err;

  always #2 clk = ~clk;

  psdiv_top dut_i (
    .clk(clk), .rst(rst), .swallow_cnt_i(swl), .prog_cnt_i(prg),
    .pair_sel_i(pair), .div_pulse_o(div_pulse), .cfg_err_o(cfg_err)
  );

  function automatic bit illegal(int a, int b, int m);
    int p;
    p = m ? 64 : 32;
    return (b < 3) || (a > b) || (a > p);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_period = 96; m_ha = 0; m_hb = 3; m_hm = 0;
      m_pulse = 0; m_err = 0;
    end else begin
      m_cnt = m_cnt + 1;
      m_pulse = (m_cnt == m_period);
      if (m_pulse) begin
        m_cnt = 0;
        m_period = (m_hm ? 64 : 32) * m_hb + m_ha;
      end
      m_err = illegal(int'(swl), int'(prg), int'(pair));
      if (!m_err) begin
        m_ha = int'(swl); m_hb = int'(prg); m_hm = int'(pair);
      end
    end
    started <= 1'b1;
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      checks++;
      if (div_pulse !== m_pulse) begin
        errors++;
        $display("FAIL %s div_pulse_o actual=%b expected=%b at %0t", tag, div_pulse, m_pulse, $time);
      end
      checks++;
      if (cfg_err !== m_err) begin
        errors++;
        $display("FAIL %s cfg_err_o actual=%b expected=%b at %0t", tag, cfg_err, m_err, $time);
      end
      if (div_pulse === 1'b1) pulses++;
    end
  end

  task automatic step(input string t, input int a, input int b, input int m, input int n);
    @(negedge clk);
    tag  = t;
    swl  = 6'(a);
    prg  = 7'(b);
    pair = m[0];
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    step("R1 R4", 0, 3, 0, 300);
    step("R2 R3", 5, 10, 0, 1000);
    step("R3", 0, 3, 1, 600);
    step("R2 A=B", 3, 3, 0, 300);
    step("R5", 7, 20, 1, 1400);
    step("R6 R9", 0, 2, 0, 3000);
    step("R10", 1, 4, 0, 300);
    step("R7 R9", 10, 5, 0, 300);
    step("R8 R9", 40, 50, 0, 300);
    step("R3 R8 legal", 40, 50, 1, 7000);
    step("R2 max", 63, 127, 1, 17000);
    checks++;
    if (pulses < 20) begin
      errors++;
      $display("FAIL R2 pulse count actual=%0d expected>=20", pulses);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule